// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock Indication

This block compares a reference strobe with a divided oscillator strobe and produces the loop error for a frequency synthesizer. Both strobes are asynchronous to the fast system clock. Each passes through a synchroniser and an edge detector. A five-state machine then tracks which input's rising edge arrived first. The error is presented in two forms. The first is a single-ended three-state output, modelled as separate source, sink and drive-enable signals. The second is a pair of active-low pulse outputs, `r_n_o` and `v_n_o`.

When the second edge of a pair arrives, both pulse outputs go low together for `OVL_CYCLES` clocks and then both return high. This guaranteed overlap removes the dead zone around phase alignment. A polarity input exchanges the roles of the two inputs on every output. The disable input and the standby input each force every detector output to its rest state: no drive, and both pulses high. A lock output is the AND of the two pulse outputs. It has its own enable, and from reset it stays low until that enable is set.

The states are ST_IDLE, ST_REF_AHEAD, ST_VCO_AHEAD, ST_OVERLAP and ST_OFF. The transitions are as follows:
- ST_IDLE goes to ST_REF_AHEAD on a reference edge alone, to ST_VCO_AHEAD on an oscillator edge alone, and to ST_OVERLAP on both edges together.
- ST_REF_AHEAD goes to ST_OVERLAP on an oscillator edge. ST_VCO_AHEAD goes to ST_OVERLAP on a reference edge.
- ST_OVERLAP goes back to ST_IDLE after `OVL_CYCLES` clocks. If a single edge arrives in that last cycle, it goes directly to the matching ahead state instead.
- Any state goes to ST_OFF while disable or standby is set. ST_OFF goes to ST_IDLE once both are clear.

Top module: `pfd_lockdet`

## Requirements
- R1: With `pol_i`=0, a reference edge ahead of the oscillator edge asserts `src_o` for each clock of the lead, and an oscillator edge ahead asserts `snk_o`. `drv_en_o` is 1 exactly when one of them is 1, and `src_o` and `snk_o` are never 1 together.
- R2: With `pol_i`=1, the roles of `src_o` and `snk_o` in R1 are exchanged.
- R3: With `pol_i`=0, `r_n_o` is low (0) for the lead clocks plus `OVL_CYCLES` when the reference edge leads, and `v_n_o` is low for the same count when the oscillator edge leads. The trailing output is low only for `OVL_CYCLES`. With `pol_i`=1, `r_n_o` and `v_n_o` exchange roles. Whenever `drv_en_o`=1, exactly one of `r_n_o` and `v_n_o` is low.
- R4: After the second edge of a pair, `r_n_o` and `v_n_o` are both low for exactly `OVL_CYCLES` clocks, and `drv_en_o`=0 throughout. This includes coincident edges, where no source or sink cycle occurs.
- R5: If `dis_i` or `stby_i` is 1 at a clock edge, then from that edge on `src_o`, `snk_o` and `drv_en_o` are 0 and `r_n_o` and `v_n_o` are 1, whatever the strobes do.
- R6: Entering disable or standby clears any pending lead. After release, a lone oscillator edge produces sink drive (`pol_i`=0), not an overlap.
- R7: `lock_o` equals `r_n_o` AND `v_n_o` while the lock enable is active. Each lead or overlap clock is therefore a low clock on `lock_o`.
- R8: After reset, `lock_o` is 0 until `ld_en_i` has been 1 at a clock edge. `ld_en_i` takes effect one clock after it is driven.
- R9: A strobe rising edge reaches the outputs on the third clock edge after it is applied. A change of `pol_i` takes effect on the next clock edge.
- R10: When the oscillator strobe runs faster than the reference strobe (period 6 vs 10 clocks, `pol_i`=0), the output settles to sink drive only, with no source cycles. With `pol_i`=1, it settles to source drive only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_strobe_i | input | 1 | Reference strobe, asynchronous |
| vco_strobe_i | input | 1 | Divided oscillator strobe, asynchronous |
| pol_i | input | 1 | Polarity swap |
| dis_i | input | 1 | Detector disable |
| stby_i | input | 1 | Standby |
| ld_en_i | input | 1 | Lock output enable |
| src_o | output | 1 | Single-ended output sources current |
| snk_o | output | 1 | Single-ended output sinks current |
| drv_en_o | output | 1 | Single-ended output driven (0 = high impedance) |
| r_n_o | output | 1 | Active-low reference-side pulse |
| v_n_o | output | 1 | Active-low oscillator-side pulse |
| lock_o | output | 1 | Lock indication |

## Verification
The bench sweeps the edge offset from six clocks of oscillator lead to six clocks of reference lead under both polarities. From the offset it computes the exact count of source, sink, pulse-low, overlap and lock-low clocks. A design that lost the overlap, or stretched it, would miss the both-low count. A design that swapped polarity in only one output form would miss one of the two mirrored counts. The bench also checks the exact clock at which an edge and a polarity change land. It checks that a pending lead does not survive a disable: a design that kept the flag would turn the next lone edge into an overlap with no drive. Finally, it checks that lock stays low from reset until enabled, and that a faster oscillator never produces a source cycle.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_REF_AHEAD = 3'd1,
        ST_VCO_AHEAD = 3'd2,
        ST_OVERLAP   = 3'd3,
        ST_OFF       = 3'd4
    } pfd_state_t;

endpackage

// File: rtl/pfd_strobe_sync.sv
module pfd_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_i,
    output logic rise_o
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;
    logic          prev_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= strobe_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[LAST-1:0], strobe_i};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= chain_q[LAST];
    end

    assign rise_o = chain_q[LAST] & ~prev_q;

endmodule

// File: rtl/pfd_fsm.sv
module pfd_fsm
    import pfd_pkg::*;
#(
    parameter int OVL_CYCLES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_rise_i,
    input  logic vco_rise_i,
    input  logic pol_i,
    input  logic off_i,
    output logic src_o,
    output logic snk_o,
    output logic drv_en_o,
    output logic r_n_o,
    output logic v_n_o
);
    localparam int CW = (OVL_CYCLES < 2) ? 1 : $clog2(OVL_CYCLES);
    localparam logic [CW-1:0] CNT_LAST = CW'(OVL_CYCLES - 1);

    pfd_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          pol_q;
    logic          up, dn, ovl;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            pol_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            pol_q   <= pol_i;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ref_rise_i && vco_rise_i) state_d = ST_OVERLAP;
                else if (ref_rise_i)          state_d = ST_REF_AHEAD;
                else if (vco_rise_i)          state_d = ST_VCO_AHEAD;
            end
            ST_REF_AHEAD: begin
                if (vco_rise_i) state_d = ST_OVERLAP;
            end
            ST_VCO_AHEAD: begin
                if (ref_rise_i) state_d = ST_OVERLAP;
            end
            ST_OVERLAP: begin
                if (cnt_q == CNT_LAST) begin
                    if (ref_rise_i && !vco_rise_i)      state_d = ST_REF_AHEAD;
                    else if (vco_rise_i && !ref_rise_i) state_d = ST_VCO_AHEAD;
                    else                                state_d = ST_IDLE;
                end
            end
            ST_OFF: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
        if (off_i) state_d = ST_OFF;
    end

    // overlap width counter
    always_comb begin
        if (state_q == ST_OVERLAP && state_d == ST_OVERLAP) cnt_d = cnt_q + CW'(1);
        else                                                 cnt_d = '0;
    end

    // outputs
    always_comb begin
        up  = 1'b0;
        dn  = 1'b0;
        ovl = 1'b0;
        unique case (state_q)
            ST_REF_AHEAD: up  = 1'b1;
            ST_VCO_AHEAD: dn  = 1'b1;
            ST_OVERLAP:   ovl = 1'b1;
            ST_IDLE, ST_OFF: ;
            default: ;
        endcase
        src_o    = pol_q ? dn : up;
        snk_o    = pol_q ? up : dn;
        drv_en_o = up | dn;
        r_n_o    = ~((pol_q ? dn : up) | ovl);
        v_n_o    = ~((pol_q ? up : dn) | ovl);
    end

endmodule

// File: rtl/pfd_lock.sv
module pfd_lock (
    input  logic clk,
    input  logic rst,
    input  logic ld_en_i,
    input  logic r_n_i,
    input  logic v_n_i,
    output logic lock_o
);
    logic en_q;

    always_ff @(posedge clk) begin
        if (rst) en_q <= 1'b0;
        else     en_q <= ld_en_i;
    end

    assign lock_o = en_q & r_n_i & v_n_i;

endmodule

// File: rtl/pfd_lockdet.sv
module pfd_lockdet #(
    parameter int SYNC_STAGES = 2,
    parameter int OVL_CYCLES  = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_strobe_i,
    input  logic vco_strobe_i,
    input  logic pol_i,
    input  logic dis_i,
    input  logic stby_i,
    input  logic ld_en_i,
    output logic src_o,
    output logic snk_o,
    output logic drv_en_o,
    output logic r_n_o,
    output logic v_n_o,
    output logic lock_o
);
    logic ref_rise, vco_rise;
    logic off_req;

    assign off_req = dis_i | stby_i;

    pfd_strobe_sync #(.STAGES(SYNC_STAGES)) u_ref_sync (
        .clk      (clk),
        .rst      (rst),
        .strobe_i (ref_strobe_i),
        .rise_o   (ref_rise)
    );

    pfd_strobe_sync #(.STAGES(SYNC_STAGES)) u_vco_sync (
        .clk      (clk),
        .rst      (rst),
        .strobe_i (vco_strobe_i),
        .rise_o   (vco_rise)
    );

    pfd_fsm #(.OVL_CYCLES(OVL_CYCLES)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .ref_rise_i (ref_rise),
        .vco_rise_i (vco_rise),
        .pol_i      (pol_i),
        .off_i      (off_req),
        .src_o      (src_o),
        .snk_o      (snk_o),
        .drv_en_o   (drv_en_o),
        .r_n_o      (r_n_o),
        .v_n_o      (v_n_o)
    );

    pfd_lock u_lock (
        .clk     (clk),
        .rst     (rst),
        .ld_en_i (ld_en_i),
        .r_n_i   (r_n_o),
        .v_n_i   (v_n_o),
        .lock_o  (lock_o)
    );

endmodule

// File: rtl/pfd_checker.sv
module pfd_checker #(
    parameter int OVL_CYCLES = 3
) (
    input logic clk,
    input logic rst,
    input logic dis_i,
    input logic stby_i,
    input logic ld_en_i,
    input logic src_o,
    input logic snk_o,
    input logic drv_en_o,
    input logic r_n_o,
    input logic v_n_o,
    input logic lock_o
);
    logic [15:0] both_low_run_q;

    always_ff @(posedge clk) begin
        if (rst)                  both_low_run_q <= '0;
        else if (!r_n_o && !v_n_o) both_low_run_q <= both_low_run_q + 16'd1;
        else                      both_low_run_q <= '0;
    end

    AST_SE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(src_o && snk_o)); // R1

    AST_DRIVE_ONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        drv_en_o |-> (r_n_o != v_n_o)); // R3

    AST_OVERLAP_FLOATS: assert property (@(posedge clk) disable iff (rst)
        (!r_n_o && !v_n_o) |-> !drv_en_o); // R4

    AST_OVERLAP_WIDTH: assert property (@(posedge clk) disable iff (rst)
        ((both_low_run_q != 16'd0) && !(!r_n_o && !v_n_o) && !$past(dis_i || stby_i))
        |-> (both_low_run_q == 16'(OVL_CYCLES))); // R4

    AST_OFF_REST: assert property (@(posedge clk) disable iff (rst)
        (dis_i || stby_i) |=> (!drv_en_o && !src_o && !snk_o && r_n_o && v_n_o)); // R5

    AST_LOCK_IS_AND: assert property (@(posedge clk) disable iff (rst)
        lock_o |-> (r_n_o && v_n_o)); // R7

    AST_LOCK_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        lock_o |-> $past(ld_en_i)); // R8

endmodule

bind pfd_lockdet pfd_checker #(.OVL_CYCLES(OVL_CYCLES)) u_pfd_checker (
    .clk      (clk),
    .rst      (rst),
    .dis_i    (dis_i),
    .stby_i   (stby_i),
    .ld_en_i  (ld_en_i),
    .src_o    (src_o),
    .snk_o    (snk_o),
    .drv_en_o (drv_en_o),
    .r_n_o    (r_n_o),
    .v_n_o    (v_n_o),
    .lock_o   (lock_o)
);

// File: tb/tb_pfd_lockdet.sv
module tb_pfd_lockdet;
    localparam int OVL = 3;

    logic clk = 1'b0;
    logic rst;
    logic ref_strobe_i, vco_strobe_i, pol_i, dis_i, stby_i, ld_en_i;
    logic src_o, snk_o, drv_en_o, r_n_o, v_n_o, lock_o;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #2 clk = ~clk;

    pfd_lockdet #(.SYNC_STAGES(2), .OVL_CYCLES(OVL)) dut (
        .clk          (clk),
        .rst          (rst),
        .ref_strobe_i (ref_strobe_i),
        .vco_strobe_i (vco_strobe_i),
        .pol_i        (pol_i),
        .dis_i        (dis_i),
        .stby_i       (stby_i),
        .ld_en_i      (ld_en_i),
        .src_o        (src_o),
        .snk_o        (snk_o),
        .drv_en_o     (drv_en_o),
        .r_n_o        (r_n_o),
        .v_n_o        (v_n_o),
        .lock_o       (lock_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // bring the machine back to idle with a coincident pair
    task automatic settle();
        @(negedge clk);
        ref_strobe_i = 1'b1; vco_strobe_i = 1'b1;
        idle(3);
        ref_strobe_i = 1'b0; vco_strobe_i = 1'b0;
        idle(12);
    endtask

    task automatic run_pair(input logic pol, input int d);
        int n_src = 0, n_snk = 0, n_drv = 0, n_rlo = 0, n_vlo = 0, n_both = 0, n_lklo = 0;
        int ra = 10;
        int va = 10 + d;
        int lead = (d < 0) ? -d : d;
        int e_src, e_snk, e_rlo, e_vlo;
        logic ref_first, vco_first;
        @(negedge clk);
        pol_i = pol;
        idle(6);
        for (int c = 0; c < 45; c++) begin
            @(negedge clk);
            n_src  += int'(src_o);
            n_snk  += int'(snk_o);
            n_drv  += int'(drv_en_o);
            n_rlo  += int'(!r_n_o);
            n_vlo  += int'(!v_n_o);
            n_both += int'(!r_n_o && !v_n_o);
            n_lklo += int'(!lock_o);
            ref_strobe_i = (c >= ra) && (c < ra + 3);
            vco_strobe_i = (c >= va) && (c < va + 3);
        end
        ref_first = (d > 0);
        vco_first = (d < 0);
        // pol 0: ref ahead -> source, r_n leads; vco ahead -> sink, v_n leads
        e_src = (pol ? vco_first : ref_first) ? lead : 0;
        e_snk = (pol ? ref_first : vco_first) ? lead : 0;
        e_rlo = OVL + ((pol ? vco_first : ref_first) ? lead : 0);
        e_vlo = OVL + ((pol ? ref_first : vco_first) ? lead : 0);
        check($sformatf("R1/R2 pol=%0d d=%0d source", pol, d), n_src, e_src);
        check($sformatf("R1/R2 pol=%0d d=%0d sink", pol, d), n_snk, e_snk);
        check($sformatf("R1 pol=%0d d=%0d drive", pol, d), n_drv, lead);
        check($sformatf("R3 pol=%0d d=%0d r_n low", pol, d), n_rlo, e_rlo);
        check($sformatf("R3 pol=%0d d=%0d v_n low", pol, d), n_vlo, e_vlo);
        check($sformatf("R4 pol=%0d d=%0d both low", pol, d), n_both, OVL);
        check($sformatf("R7 pol=%0d d=%0d lock low", pol, d), n_lklo, lead + OVL);
    endtask

    task automatic run_freq(input logic pol);
        int n_src = 0, n_snk = 0;
        @(negedge clk);
        pol_i = pol;
        for (int c = 0; c < 360; c++) begin
            @(negedge clk);
            if (c >= 60) begin
                n_src += int'(src_o);
                n_snk += int'(snk_o);
            end
            ref_strobe_i = (c % 10) < 3;
            vco_strobe_i = (c % 6) < 3;
        end
        ref_strobe_i = 1'b0; vco_strobe_i = 1'b0;
        if (pol == 1'b0) begin
            check("R10 pol=0 faster vco no source", n_src, 0);
            check("R10 pol=0 faster vco sinks", int'(n_snk > 0), 1);
        end else begin
            check("R10 pol=1 faster vco no sink", n_snk, 0);
            check("R10 pol=1 faster vco sources", int'(n_src > 0), 1);
        end
        settle();
    endtask

    task automatic run_off(input bit use_stby);
        int bad = 0;
        string tag = use_stby ? "R5 standby" : "R5 disable";
        @(negedge clk);
        pol_i = 1'b0;
        if (use_stby) stby_i = 1'b1; else dis_i = 1'b1;
        for (int c = 0; c < 30; c++) begin
            @(negedge clk);
            if (drv_en_o || src_o || snk_o || !r_n_o || !v_n_o) bad++;
            ref_strobe_i = (c >= 3) && (c < 6);
            vco_strobe_i = (c >= 12) && (c < 15);
        end
        check(tag, bad, 0);
        dis_i = 1'b0; stby_i = 1'b0;
        idle(10);
        check({tag, " released rest"}, int'(r_n_o && v_n_o && !drv_en_o), 1);
    endtask

    initial begin
        rst = 1'b1;
        ref_strobe_i = 1'b0; vco_strobe_i = 1'b0;
        pol_i = 1'b0; dis_i = 1'b0; stby_i = 1'b0; ld_en_i = 1'b0;
        idle(5);
        rst = 1'b0;
        @(negedge clk);
        check("R5 reset drive", int'(drv_en_o), 0);
        check("R3 reset pulses high", int'(r_n_o && v_n_o), 1);
        check("R8 reset lock low", int'(lock_o), 0);

        begin : lock_hold
            int hi = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                hi += int'(lock_o);
            end
            check("R8 lock held low before enable", hi, 0);
        end
        ld_en_i = 1'b1;
        @(negedge clk);
        check("R8 lock after enable", int'(lock_o), 1);
        check("R7 lock equals pulse AND", int'(lock_o), int'(r_n_o && v_n_o));

        // R9: exact latency of a strobe edge and of a polarity change
        ref_strobe_i = 1'b1;
        @(negedge clk);
        check("R9 latency +1", int'(src_o), 0);
        @(negedge clk);
        ref_strobe_i = 1'b0;
        check("R9 latency +2", int'(src_o), 0);
        @(negedge clk);
        check("R9 latency +3 source", int'(src_o), 1);
        pol_i = 1'b1;
        @(negedge clk);
        check("R9 polarity next edge sink", int'(snk_o), 1);
        check("R9 polarity next edge source", int'(src_o), 0);
        pol_i = 1'b0;
        settle();

        for (int p = 0; p < 2; p++) begin
            for (int d = -6; d <= 6; d++) begin
                run_pair(p[0], d);
            end
        end

        run_freq(1'b0);
        run_freq(1'b1);

        run_off(1'b0);
        run_off(1'b1);

        // R6: pending lead cleared by disable
        @(negedge clk);
        pol_i = 1'b0;
        ref_strobe_i = 1'b1;
        idle(3);
        ref_strobe_i = 1'b0;
        idle(2);
        check("R6 lead pending before disable", int'(src_o), 1);
        dis_i = 1'b1;
        @(negedge clk);
        check("R6 disable rest", int'(!drv_en_o && r_n_o && v_n_o), 1);
        dis_i = 1'b0;
        idle(3);
        vco_strobe_i = 1'b1;
        idle(3);
        vco_strobe_i = 1'b0;
        idle(2);
        check("R6 lone vco edge sinks", int'(snk_o), 1);
        check("R6 no overlap after clear", int'(r_n_o), 1);
        check("R6 v_n low", int'(v_n_o), 0);
        settle();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule